// File: doc/BRIEF.md
# Reset-Qualified Clock Edge Pulser

This block watches a slow, roughly square processor clock from a faster system clock domain. It produces a single-cycle strobe for every rising transition and a separate single-cycle strobe for every falling transition of that slow clock. Downstream logic uses these strobes as enables, so they must be complete and must arrive in a predictable order.

The slow clock may already be running when reset is released, and it may be high at that moment. An edge seen at that point could be a partial or out-of-order event. The block therefore stays silent after reset until it has seen the slow clock go low once. From then on it raises a sticky clock-good flag and passes every edge through. The first strobe it emits is always a rising one, and rising and falling strobes alternate after that.

The slow clock first passes through a synchronizer of `SYNC_STAGES` flops. An edge detector follows, then a qualifying stage with registered outputs.

Top module: `clk_edge_pulser`

## Requirements
- R1: While `rst` is high, `rise_pulse`, `fall_pulse` and `clk_good` are all low, whatever `slow_clk` does.
- R2: With `SYNC_STAGES`=2, take a value of `slow_clk` sampled at system-clock edge n. A 0-to-1 change between samples n-1 and n sets `rise_pulse` high after edge n+2, provided `clk_good` was already high before that edge.
- R3: Every strobe on `rise_pulse` or `fall_pulse` lasts exactly one system-clock cycle, however long the slow clock stays at its level.
- R4: After reset is released, no strobe is emitted before the first 1-to-0 change of the synchronized slow clock. This includes the apparent rising edge seen when `slow_clk` is already high at release.
- R5: `clk_good` goes high at the edge where the first falling strobe after reset would appear. No falling strobe is emitted at that edge.
- R6: Once high, `clk_good` stays high until the next reset, even when the slow clock stops.
- R7: The first strobe after reset is a rising one, and after that rising and falling strobes strictly alternate.
- R8: `rise_pulse` and `fall_pulse` are never high in the same cycle, and neither is high while `clk_good` is low.
- R9: A reset asserted during operation clears `clk_good`, and qualification restarts: the block again waits for a new falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `slow_clk` |
| rst | input | 1 | Asynchronous active-high reset |
| slow_clk | input | 1 | Slow processor clock to be observed (asynchronous) |
| rise_pulse | output | 1 | One-cycle strobe per qualified rising edge |
| fall_pulse | output | 1 | One-cycle strobe per qualified falling edge |
| clk_good | output | 1 | Sticky flag: a falling edge has been seen since reset |

## Verification
The hardest case to reach from the ports is reset being released while the slow clock is high. The synchronizer then shows a spurious rising transition that must be swallowed. The stimulus holds `slow_clk` high through the release, and holds it again through a mid-run reset, before letting it fall. A second release with the clock low, followed at once by a rise, confirms that a genuine rising edge arriving before any fall is also dropped. A behavioural history-queue model predicts every output on every cycle.

// File: rtl/pulser_pkg.sv
package pulser_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  // Classify a level transition between two consecutive samples.
  function automatic edge_evt_t classify_edge(logic cur, logic prev);
    edge_evt_t e;
    e.rise = cur & ~prev;
    e.fall = ~cur & prev;
    return e;
  endfunction

  // Qualification becomes true on the first fall and stays true.
  function automatic logic next_armed(logic armed, edge_evt_t e);
    return armed | e.fall;
  endfunction

  // A strobe is only allowed when already qualified before this edge.
  function automatic logic gate_strobe(logic evt, logic armed);
    return evt & armed;
  endfunction

endpackage

// File: rtl/pulser_sync.sv
module pulser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= '0;
    else     chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/pulser_edge.sv
module pulser_edge
  import pulser_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      level,
  output edge_evt_t evt
);
  logic prev_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign evt = classify_edge(level, prev_q);
endmodule

// File: rtl/pulser_gate.sv
module pulser_gate
  import pulser_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  edge_evt_t evt,
  output logic      armed,
  output logic      rise_o,
  output logic      fall_o,
  output logic      good_o
);
  logic armed_q;
  logic rise_q;
  logic fall_q;
  logic good_q;
  logic armed_d;

  assign armed_d = next_armed(armed_q, evt);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      armed_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      rise_q  <= gate_strobe(evt.rise, armed_q);
      fall_q  <= gate_strobe(evt.fall, armed_q);
      good_q  <= armed_d;
    end
  end

  assign armed  = armed_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign good_o = good_q;
endmodule

// File: rtl/clk_edge_pulser.sv
module clk_edge_pulser
  import pulser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_clk,
  output logic rise_pulse,
  output logic fall_pulse,
  output logic clk_good
);
  logic      synced_lvl;
  edge_evt_t evt;
  logic      rise_evt;
  logic      fall_evt;
  logic      armed;

  pulser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (slow_clk),
    .q   (synced_lvl)
  );

  pulser_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (synced_lvl),
    .evt   (evt)
  );

  assign rise_evt = evt.rise;
  assign fall_evt = evt.fall;

  pulser_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .armed  (armed),
    .rise_o (rise_pulse),
    .fall_o (fall_pulse),
    .good_o (clk_good)
  );
endmodule

// File: rtl/pulser_chk.sv
module pulser_chk (
  input logic clk,
  input logic rst,
  input logic rise_pulse,
  input logic fall_pulse,
  input logic clk_good,
  input logic rise_evt,
  input logic fall_evt,
  input logic armed
);
  logic last_rise_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             last_rise_q <= 1'b0;
    else if (rise_pulse) last_rise_q <= 1'b1;
    else if (fall_pulse) last_rise_q <= 1'b0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rise_pulse && !fall_pulse && !clk_good));

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);

  // R4
  no_early_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && !armed) |=> !rise_pulse);

  // R5
  good_from_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_good) |-> $past(fall_evt));

  // R6
  good_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    clk_good |=> clk_good);

  // R7
  fall_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |-> last_rise_q);

  // R7
  rise_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |-> !last_rise_q);

  // R8
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise_pulse && fall_pulse));

  // R8
  gated_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_pulse || fall_pulse) |-> clk_good);
endmodule

bind clk_edge_pulser pulser_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rise_pulse (rise_pulse),
  .fall_pulse (fall_pulse),
  .clk_good   (clk_good),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .armed      (armed)
);

// File: tb/sim_clk_edge_pulser.sv
`timescale 1ns/1ps
module sim_clk_edge_pulser;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow = 1'b0;
  logic rise, fall, good;

  int    vectors = 0;
  int    misses  = 0;
  int    cyc     = 0;
  string tag     = "R1";
  bit    hist[$];
  bit    armed_m;
  bit    er, ef, eg;
  int    last_kind = 0;   // 0 none, 1 rise, 2 fall
  bit    done = 0;

  always #2 clk = ~clk;

  clk_edge_pulser #(.SYNC_STAGES(S)) u0 (
    .clk        (clk),
    .rst        (rst),
    .slow_clk   (slow),
    .rise_pulse (rise),
    .fall_pulse (fall),
    .clk_good   (good)
  );

  task automatic chk(string req, string nm, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: %s actual=%0b expected=%0b cycle %0d", tag, req, nm, act, exp, cyc);
    end
  endtask

  // Reference model: history of samples, output depends on samples S and S+1 edges ago.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      hist.delete();
      for (int i = 0; i < S + 2; i++) hist.push_back(1'b0);
      armed_m = 0; er = 0; ef = 0; eg = 0; last_kind = 0;
    end else begin
      hist.push_back(slow);
      void'(hist.pop_front());
      er = hist[1] && !hist[0] && armed_m;
      ef = !hist[1] && hist[0] && armed_m;
      if (!hist[1] && hist[0]) armed_m = 1;
      eg = armed_m;
    end
    #1;
    if (!done) begin
      chk("R2 R3 R4", "rise_pulse", rise, er);
      chk("R4 R8",    "fall_pulse", fall, ef);
      chk("R5 R6",    "clk_good",   good, eg);
      if (rise === 1'b1) begin
        vectors++;
        if (last_kind == 1) begin
          misses++;
          $display("FAIL R7: rise after rise actual=%0d expected=2", last_kind);
        end
        last_kind = 1;
      end
      if (fall === 1'b1) begin
        vectors++;
        if (last_kind != 1) begin
          misses++;
          $display("FAIL R7: fall not preceded by rise actual=%0d expected=1", last_kind);
        end
        last_kind = 2;
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(int hi, int lo, int periods);
    repeat (periods) begin
      slow = 1'b1; wait_cyc(hi);
      slow = 1'b0; wait_cyc(lo);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    vectors++;
    misses++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: slow clock toggles during reset
    tag = "R1";
    wait_cyc(2);
    toggle(2, 2, 3);
    slow = 1'b1; wait_cyc(3);
    // R4: release with slow clock high
    tag = "R4";
    rst = 1'b0;
    wait_cyc(8);
    slow = 1'b0;            // R5: first fall arms
    tag = "R5";
    wait_cyc(6);
    tag = "R2";
    toggle(5, 5, 4);
    tag = "R3";
    toggle(3, 3, 4);
    toggle(2, 7, 3);
    toggle(9, 3, 2);
    // R6: slow clock stops
    tag = "R6";
    wait_cyc(20);
    // R9: reset mid-run with slow high
    tag = "R9";
    slow = 1'b1; wait_cyc(4);
    rst = 1'b1; wait_cyc(3);
    rst = 1'b0; wait_cyc(6);
    slow = 1'b0; wait_cyc(6);
    toggle(4, 4, 3);
    // R4: release low, a genuine rise before any fall is dropped
    tag = "R4";
    rst = 1'b1; wait_cyc(3);
    rst = 1'b0; wait_cyc(3);
    slow = 1'b1; wait_cyc(6);
    slow = 1'b0; wait_cyc(6);
    tag = "R8";
    toggle(3, 4, 4);
    wait_cyc(6);
    finish_run();
  end
endmodule